// File: doc/BRIEF.md
# Triggered Pulse-Width Generator

This block emits one output pulse of programmable length for each trigger strobe it accepts. When it accepts a trigger it captures a width value W, raises its output, and counts W clock periods down to zero. It then stops at zero without wrapping and holds the output low until it accepts another trigger. With a 25 MHz system clock one width step is 40 ns. The trigger comes from a separate rate source at the wanted repetition rate, so the pulse frequency is set upstream and this block sets only the pulse length.

The width can be given in two ways. It can be a plain binary count, or it can be three packed decimal digits taken from decimal switch settings. An input pin selects the format. The control is a two-state machine. IDLE waits for a trigger with a non-zero width (transition IDLE→RUN, "accept"). RUN counts down and returns when the count reaches its last step (transition RUN→IDLE, "finish"). A trigger with a zero width leaves the machine in IDLE ("reject"). Every other cycle keeps the current state ("hold").

Top module: `pw_pulse_gen`

## Requirements
- R1: A synchronous reset drives `pulse_out` low and leaves the block idle from the next clock edge on, even when a pulse is in progress.
- R2: `pulse_out` is registered. It goes high at the same clock edge that samples an accepted trigger.
- R3: In binary mode (`bcd_mode`=0) the 12-bit `width_in` is an unsigned count W. For any W from 1 to 4095, `pulse_out` stays high for exactly W clock cycles.
- R4: A trigger that arrives with a decoded width of zero produces no pulse.
- R5: A trigger that arrives while `pulse_out` is high is ignored and does not lengthen the pulse.
- R6: In decimal mode (`bcd_mode`=1) `width_in[11:8]` holds the hundreds digit, `[7:4]` the tens digit and `[3:0]` the units digit. The width is their decimal value, from 0 to 999.
- R7: In decimal mode a digit code above 9 counts as 9.
- R8: `width_in` and `bcd_mode` are read only at the edge that accepts a trigger. Changes to them during a pulse have no effect on it.
- R9: If the trigger is held high, a new pulse starts one cycle after the previous pulse ends, so the output is low for exactly one cycle between pulses.
- R10: The internal count stops at zero and never wraps while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Trigger strobe, sampled on each rising edge |
| bcd_mode | input | 1 | 1 = width given as packed decimal digits, 0 = binary |
| width_in | input | 12 | Pulse width in clock periods |
| pulse_out | output | 1 | Registered pulse output |

## Verification
A wrong internal state shows up at `pulse_out` as a length error that only becomes visible at the end of a pulse. A bad load value, a skipped decrement or a counter that wraps makes the pulse one or more cycles longer or shorter than W. A machine stuck in RUN keeps the output high well past W. A machine that wrongly returns to IDLE shows up when a trigger held high during the pulse restarts it early. The bench therefore measures each pulse to the cycle, checks the single low cycle between back-to-back pulses, and confirms that the output stays low after each pulse.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [0:0] {
        PW_IDLE = 1'b0,
        PW_RUN  = 1'b1
    } pw_state_e;
endpackage

// File: rtl/pw_width_decode.sv
module pw_width_decode #(
    parameter int DIGITS = 3
) (
    input  logic                  bcd_mode,
    input  logic [DIGITS*4-1:0]   field,
    output logic [DIGITS*4-1:0]   value
);
    localparam int FIELD_W = DIGITS * 4;

    logic [3:0] dig [DIGITS];

    // each decimal digit clamped to 9
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        always_comb begin
            if (field[g*4 +: 4] > 4'd9) dig[g] = 4'd9;
            else                        dig[g] = field[g*4 +: 4];
        end
    end

    logic [FIELD_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            acc = acc * FIELD_W'(10) + FIELD_W'(dig[i]);
        end
        value = bcd_mode ? acc : field;
    end
endmodule

// File: rtl/pw_sat_counter.sv
module pw_sat_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst)                     count <= '0;
        else if (load)               count <= load_val;
        else if (dec && count != '0) count <= count - CNT_W'(1);
    end

    assign last = (count == CNT_W'(1));
endmodule

// File: rtl/pw_pulse_gen.sv
module pw_pulse_gen #(
    parameter int DIGITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig,
    input  logic                bcd_mode,
    input  logic [DIGITS*4-1:0] width_in,
    output logic                pulse_out
);
    import pw_pkg::*;

    localparam int FIELD_W = DIGITS * 4;

    pw_state_e          state, state_n;
    logic [FIELD_W-1:0] wval;
    logic [FIELD_W-1:0] cnt;
    logic               cnt_last;
    logic               accept;
    logic               pulse_q;

    pw_width_decode #(.DIGITS(DIGITS)) u_dec (
        .bcd_mode (bcd_mode),
        .field    (width_in),
        .value    (wval)
    );

    assign accept = (state == PW_IDLE) && trig && (wval != '0);

    pw_sat_counter #(.CNT_W(FIELD_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (wval),
        .dec      (state == PW_RUN),
        .count    (cnt),
        .last     (cnt_last)
    );

    // next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            PW_IDLE: if (accept)   state_n = PW_RUN;
            PW_RUN:  if (cnt_last) state_n = PW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= PW_IDLE;
        else     state <= state_n;
    end

    // registered output
    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= (state_n == PW_RUN);
    end

    assign pulse_out = pulse_q;
endmodule

// File: rtl/pw_pulse_gen_chk.sv
module pw_pulse_gen_chk #(
    parameter int FIELD_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               trig,
    input logic               pulse_out,
    input pw_pkg::pw_state_e  state,
    input logic [FIELD_W-1:0] count,
    input logic [FIELD_W-1:0] wval
);
    import pw_pkg::*;

    AST_RESET_LOW: assert property (@(posedge clk) rst |=> (!pulse_out && count == '0)); // R1
    AST_START: assert property (@(posedge clk) disable iff (rst)
        (state == PW_IDLE && trig && wval != '0) |=> (pulse_out && count == $past(wval))); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == PW_RUN && count > FIELD_W'(1)) |=> pulse_out); // R3
    AST_END: assert property (@(posedge clk) disable iff (rst)
        (state == PW_RUN && count == FIELD_W'(1)) |=> (!pulse_out && count == '0)); // R3
    AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (state == PW_IDLE && trig && wval == '0) |=> !pulse_out); // R4
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (state == PW_RUN && count > FIELD_W'(1)) |=> (count == $past(count) - FIELD_W'(1))); // R5
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (state == PW_IDLE && !trig) |=> (count == '0 && !pulse_out)); // R10
endmodule

bind pw_pulse_gen pw_pulse_gen_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .pulse_out (pulse_out),
    .state     (state),
    .count     (cnt),
    .wval      (wval)
);

// File: tb/pw_pulse_gen_bench.sv
module pw_pulse_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic        bcd_mode = 1'b0;
    logic [11:0] width_in = '0;
    logic        pulse_out;

    int n_vec = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pw_pulse_gen u_pw_pulse_gen (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .bcd_mode  (bcd_mode),
        .width_in  (width_in),
        .pulse_out (pulse_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one-cycle trigger, then measure the high time and the low level after it
    task automatic fire(input string req, input logic b, input logic [11:0] w, input int exp);
        int n = 0;
        @(negedge clk); trig = 1'b1; bcd_mode = b; width_in = w;
        @(negedge clk); trig = 1'b0;
        while (pulse_out && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check(req, n, exp);
        @(negedge clk);
        check({req, " low after"}, int'(pulse_out), 0);
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset level", int'(pulse_out), 0);
    endtask

    // R5/R8: trigger held and width changed while the pulse runs
    task automatic t_ignore;
        int n = 0;
        @(negedge clk); trig = 1'b1; bcd_mode = 1'b0; width_in = 12'd10;
        @(negedge clk); width_in = 12'd200; n = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); if (pulse_out) n++;
        end
        trig = 1'b0; width_in = 12'd3;
        while (pulse_out && n < 5000) begin
            @(negedge clk);
            if (pulse_out) n++;
        end
        check("R5 R8 busy trigger ignored", n, 10);
    endtask

    // R9: continuous trigger gives H H H L repeating for W=3
    task automatic t_held;
        int exp_pat [8] = '{1, 1, 1, 0, 1, 1, 1, 0};
        @(negedge clk); trig = 1'b1; bcd_mode = 1'b0; width_in = 12'd3;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R9 held trigger pattern", int'(pulse_out), exp_pat[k]);
        end
        trig = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 idle after release", int'(pulse_out), 0);
    endtask

    // R1: reset in the middle of a pulse
    task automatic t_reset_mid;
        @(negedge clk); trig = 1'b1; bcd_mode = 1'b0; width_in = 12'd50;
        @(negedge clk); trig = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 pulse running", int'(pulse_out), 1);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset aborts", int'(pulse_out), 0);
        repeat (60) @(negedge clk);
        check("R10 stays idle", int'(pulse_out), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        fire("R2 R3 width 1", 1'b0, 12'd1, 1);
        fire("R3 width 5", 1'b0, 12'd5, 5);
        fire("R3 width 250", 1'b0, 12'd250, 250);
        fire("R3 width 4095", 1'b0, 12'hFFF, 4095);
        fire("R4 zero binary", 1'b0, 12'd0, 0);
        fire("R6 decimal 123", 1'b1, 12'h123, 123);
        fire("R6 decimal 999", 1'b1, 12'h999, 999);
        fire("R4 zero decimal", 1'b1, 12'h000, 0);
        fire("R7 clamp 1AF", 1'b1, 12'h1AF, 199);
        t_ignore();
        t_held();
        t_reset_mid();
        fire("R10 after idle", 1'b0, 12'd7, 7);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule